// File: doc/BRIEF.md
# Wake and Acknowledge Watchdog Controller

This block wakes a sleeping host at a fixed period and watches for the host to answer. It runs on a slow tick enable of roughly 10 ms, generated elsewhere. At each interval boundary it raises a short wake pulse. The host must answer with a rising edge on its acknowledge line before a deadline that falls a fixed number of ticks ahead of the next boundary. If no valid answer arrives, the block does not wake the host at the next boundary. It pulls the host's active-low reset line low instead and holds it there for a fixed reset width.

The reset output is an open-drain enable: a 1 on `rstn_pull` means the line is pulled low. After chip reset the block keeps the host in reset until a one-time configuration strobe delivers the interval length in ticks. It then runs a full reset pulse, followed by one interval with no wake pulse, and then enters its regular period. A manual-reset input, already debounced, overrides everything else. When it is released, the block starts a fresh reset pulse.

Top module: `wakeack_wdog`

## Requirements
- R1: From `rst_n` low, and until a configuration strobe is accepted, `rstn_pull` is 1 and `wake` is 0, however many ticks pass.
- R2: The interval accepted from `cfg_ticks` is clamped up to a floor of WAKE_TICKS + DEADLINE_TICKS + 1 ticks (5 with default parameters). Requests at or above the floor are used unchanged.
- R3: After the strobe, `rstn_pull` stays 1 for RESET_TICKS ticks. An interval with no wake pulse follows, and it needs no acknowledge. `wake` first rises RESET_TICKS + interval ticks after the strobe.
- R4: Later boundaries come every interval ticks. At each boundary where the previous interval was acknowledged, `wake` is high for WAKE_TICKS ticks.
- R5: An acknowledge is a 0-to-1 transition of `done_in` after a two-flop synchronizer. Only the first transition in an interval is examined, and the detector is re-armed only at a boundary. It counts only if it is seen while the interval position, counted in ticks from the boundary starting at 0, is below interval − DEADLINE_TICKS. A level held high across a boundary does not count again.
- R6: An acknowledge seen while `wake` is high drops `wake` before the next tick.
- R7: At a boundary with no counted acknowledge, `wake` stays 0 and `rstn_pull` goes to 1 for RESET_TICKS ticks. A no-wake interval follows, so the spacing from reset start to the next `wake` rise is RESET_TICKS + interval ticks.
- R8: While `mrst_in` is 1, `wake` is 0 and `rstn_pull` is 1 from the next clock, whatever the state. On release, a full RESET_TICKS reset pulse runs, then a no-wake interval, and the configured interval is kept.
- R9: The interval is loaded only once. A strobe on `cfg_valid` after configuration leaves the period unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low chip reset |
| tick | input | 1 | One-cycle slow time-base enable (~10 ms) |
| cfg_valid | input | 1 | Strobe that loads the interval length |
| cfg_ticks | input | CNT_W | Requested interval length in ticks |
| done_in | input | 1 | Asynchronous acknowledge from the host |
| mrst_in | input | 1 | Debounced manual reset, active high |
| wake | output | 1 | Wake pulse to the host, rests low |
| rstn_pull | output | 1 | Open-drain enable; 1 pulls the host reset low |

## Verification
The assertions assume that `tick` is a single-cycle enable, well spaced compared with the three-clock acknowledge path, and that `cfg_ticks` fits in CNT_W bits. The stimulus therefore drives `tick` one cycle in four. It places every acknowledge, configuration strobe and manual-reset release on the falling clock edge just after a tick, so that each event lands at a known interval position. Each acknowledge pulse is two clocks wide, long enough for the synchronizer to see it and short enough to finish before the next tick.

// File: rtl/wakeack_pkg.sv
package wakeack_pkg;

  typedef enum logic [1:0] {
    ST_CFG  = 2'd0,
    ST_HOLD = 2'd1,
    ST_RSTP = 2'd2,
    ST_RUN  = 2'd3
  } wk_state_e;

  // Raise a requested interval to the smallest legal length.
  function automatic logic [31:0] clamp_ivl(input logic [31:0] req,
                                            input logic [31:0] floor_v);
    return (req < floor_v) ? floor_v : req;
  endfunction

  // True while an acknowledge at this position still beats the deadline.
  function automatic logic before_deadline(input logic [31:0] pos,
                                           input logic [31:0] ivl,
                                           input logic [31:0] guard);
    return (pos + guard) < ivl;
  endfunction

endpackage

// File: rtl/wakeack_ack_edge.sv
module wakeack_ack_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic done_async,
  input  logic rearm,
  output logic ack_edge
);
  logic sync1_q, sync2_q, prev_q, armed_q;
  logic rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      sync1_q <= done_async;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  assign rise     = sync2_q && !prev_q;
  assign ack_edge = rise && armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      armed_q <= 1'b1;
    else if (rearm)  armed_q <= 1'b1;
    else if (rise)   armed_q <= 1'b0;
  end

endmodule

// File: rtl/wakeack_fsm.sv
module wakeack_fsm
  import wakeack_pkg::*;
#(
  parameter int WAKE_TICKS     = 2,
  parameter int DEADLINE_TICKS = 2,
  parameter int RESET_TICKS    = 32,
  parameter int CNT_W          = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cfg_valid,
  input  logic [CNT_W-1:0] cfg_ticks,
  input  logic             mrst,
  input  logic             ack_edge,
  output logic             wake,
  output logic             pull,
  output logic             rearm
);
  localparam int MIN_IVL = WAKE_TICKS + DEADLINE_TICKS + 1;
  localparam int RCNT_W  = $clog2(RESET_TICKS + 1);
  localparam int WCNT_W  = $clog2(WAKE_TICKS + 1);

  wk_state_e         state_q;
  logic              configured_q, first_q, acked_q, wake_q, pull_q;
  logic [CNT_W-1:0]  ivl_q, pos_q;
  logic [RCNT_W-1:0] rcnt_q;
  logic [WCNT_W-1:0] wcnt_q;

  // Named internal events used by the assertions below.
  logic running, boundary, ack_ok;
  assign running  = (state_q == ST_RUN);
  assign boundary = running && tick && !mrst && (pos_q == ivl_q - CNT_W'(1));
  assign ack_ok   = running && ack_edge &&
                    before_deadline(32'(pos_q), 32'(ivl_q), 32'(DEADLINE_TICKS));
  assign rearm    = !running || boundary;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_CFG;
      configured_q <= 1'b0;
      ivl_q        <= CNT_W'(MIN_IVL);
      pos_q        <= '0;
      rcnt_q       <= '0;
      wcnt_q       <= '0;
      wake_q       <= 1'b0;
      pull_q       <= 1'b1;
      first_q      <= 1'b1;
      acked_q      <= 1'b0;
    end else if (mrst) begin
      state_q <= ST_HOLD;
      wake_q  <= 1'b0;
      pull_q  <= 1'b1;
      pos_q   <= '0;
      rcnt_q  <= '0;
      wcnt_q  <= '0;
      first_q <= 1'b1;
      acked_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_CFG: begin
          if (cfg_valid) begin
            ivl_q        <= CNT_W'(clamp_ivl(32'(cfg_ticks), 32'(MIN_IVL)));
            configured_q <= 1'b1;
            rcnt_q       <= '0;
            state_q      <= ST_RSTP;
          end
        end
        ST_HOLD: begin
          rcnt_q  <= '0;
          state_q <= configured_q ? ST_RSTP : ST_CFG;
        end
        ST_RSTP: begin
          if (tick) begin
            if (rcnt_q == RCNT_W'(RESET_TICKS - 1)) begin
              state_q <= ST_RUN;
              pull_q  <= 1'b0;
              pos_q   <= '0;
              first_q <= 1'b1;
              acked_q <= 1'b0;
            end else begin
              rcnt_q <= rcnt_q + RCNT_W'(1);
            end
          end
        end
        default: begin // ST_RUN
          if (ack_ok) acked_q <= 1'b1;
          if (ack_edge && wake_q) wake_q <= 1'b0;
          if (tick && wake_q) begin
            if (wcnt_q == WCNT_W'(WAKE_TICKS - 1)) wake_q <= 1'b0;
            else                                    wcnt_q <= wcnt_q + WCNT_W'(1);
          end
          if (boundary) begin
            pos_q   <= '0;
            acked_q <= 1'b0;
            first_q <= 1'b0;
            if (first_q || acked_q || ack_ok) begin
              wake_q <= 1'b1;
              wcnt_q <= '0;
            end else begin
              wake_q  <= 1'b0;
              pull_q  <= 1'b1;
              rcnt_q  <= '0;
              state_q <= ST_RSTP;
            end
          end else if (tick) begin
            pos_q <= pos_q + CNT_W'(1);
          end
        end
      endcase
    end
  end

  assign wake = wake_q;
  assign pull = pull_q;

  AST_IVL_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    configured_q |-> (ivl_q >= CNT_W'(MIN_IVL))); // R2
  AST_WAKE_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |-> (pos_q < CNT_W'(WAKE_TICKS))); // R4
  AST_ACK_CUTS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (running && ack_edge && wake_q && !boundary) |=> !wake_q); // R6
  AST_MISS_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !first_q && !acked_q && !ack_ok) |=> (pull_q && !wake_q)); // R7
  AST_MRST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    mrst |=> (pull_q && !wake_q)); // R8
  AST_QUIET_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    pull_q |-> !wake_q); // R1

endmodule

// File: rtl/wakeack_wdog.sv
module wakeack_wdog #(
  parameter int WAKE_TICKS     = 2,
  parameter int DEADLINE_TICKS = 2,
  parameter int RESET_TICKS    = 32,
  parameter int CNT_W          = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cfg_valid,
  input  logic [CNT_W-1:0] cfg_ticks,
  input  logic             done_in,
  input  logic             mrst_in,
  output logic             wake,
  output logic             rstn_pull
);
  logic ack_edge, rearm;

  wakeack_ack_edge u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .done_async (done_in),
    .rearm      (rearm),
    .ack_edge   (ack_edge)
  );

  wakeack_fsm #(
    .WAKE_TICKS     (WAKE_TICKS),
    .DEADLINE_TICKS (DEADLINE_TICKS),
    .RESET_TICKS    (RESET_TICKS),
    .CNT_W          (CNT_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .cfg_valid (cfg_valid),
    .cfg_ticks (cfg_ticks),
    .mrst      (mrst_in),
    .ack_edge  (ack_edge),
    .wake      (wake),
    .pull      (rstn_pull),
    .rearm     (rearm)
  );

endmodule

// File: tb/wakeack_wdog_test.sv
module wakeack_wdog_test;
  localparam int CLK_PERIOD = 10;
  localparam int W   = 2;
  localparam int D   = 2;
  localparam int R   = 32;
  localparam int CW  = 16;
  localparam int NV  = 7;

  // {requested interval, ack offset (255 = none), effective interval, miss}
  localparam logic [24:0] VECS [NV] = '{
    {8'd10, 8'd0,   8'd10, 1'b0},
    {8'd10, 8'd7,   8'd10, 1'b0},
    {8'd10, 8'd8,   8'd10, 1'b1},
    {8'd10, 8'd255, 8'd10, 1'b1},
    {8'd3,  8'd2,   8'd5,  1'b0},
    {8'd5,  8'd3,   8'd5,  1'b1},
    {8'd20, 8'd17,  8'd20, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic cfg_valid = 1'b0;
  logic [CW-1:0] cfg_ticks = '0;
  logic done_in = 1'b0;
  logic mrst_in = 1'b0;
  logic wake, rstn_pull;

  logic [1:0] div = 2'd0;
  int tcount = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  wakeack_wdog #(.WAKE_TICKS(W), .DEADLINE_TICKS(D), .RESET_TICKS(R), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_valid(cfg_valid),
    .cfg_ticks(cfg_ticks), .done_in(done_in), .mrst_in(mrst_in),
    .wake(wake), .rstn_pull(rstn_pull)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    div  <= div + 2'd1;
    tick <= (div == 2'd3);
  end

  always @(posedge clk) if (tick) tcount <= tcount + 1;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at tick %0d", req, act, exp, tcount);
    end
  endtask

  task automatic wait_until(input int target);
    while (tcount < target) @(negedge clk);
  endtask

  task automatic por();
    rst_n = 1'b0; done_in = 1'b0; mrst_in = 1'b0; cfg_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic configure(input int ivl, output int base);
    wait_until(tcount + 1);
    cfg_ticks = CW'(ivl);
    cfg_valid = 1'b1;
    base = tcount;
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic pulse_done();
    done_in = 1'b1;
    repeat (2) @(negedge clk);
    done_in = 1'b0;
  endtask

  task automatic first_wake(input int ivl, input int eff, output int base);
    int cb;
    configure(ivl, cb);
    wait_until(cb + R + eff - 1);
    chk("R3 no wake before first boundary", wake, 1'b0);
    chk("R3 reset released", rstn_pull, 1'b0);
    wait_until(cb + R + eff);
    chk("R3 first wake", wake, 1'b1);
    base = tcount;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int base;
    int b2;
    int r;

    // R1: reset and unconfigured state
    por();
    chk("R1 pull after reset", rstn_pull, 1'b1);
    chk("R1 wake after reset", wake, 1'b0);
    wait_until(tcount + 50);
    chk("R1 pull while unconfigured", rstn_pull, 1'b1);
    chk("R1 wake while unconfigured", wake, 1'b0);

    // Vector table: R2 clamp, R4 period, R5 deadline, R6 cut, R7 miss
    for (int i = 0; i < NV; i++) begin
      int v_ivl, v_ack, v_eff;
      logic v_miss;
      v_ivl  = int'(VECS[i][24:17]);
      v_ack  = int'(VECS[i][16:9]);
      v_eff  = int'(VECS[i][8:1]);
      v_miss = VECS[i][0];
      por();
      first_wake(v_ivl, v_eff, base);
      if (v_ack == 0) begin
        pulse_done();
        wait_until(base + 1);
        chk("R6 wake cut by acknowledge", wake, 1'b0);
      end else begin
        wait_until(base + W - 1);
        chk("R4 wake width high", wake, 1'b1);
        wait_until(base + W);
        chk("R4 wake width end", wake, 1'b0);
        if (v_ack != 255) begin
          wait_until(base + v_ack);
          pulse_done();
        end
      end
      wait_until(base + v_eff - 1);
      chk("R2 R4 quiet before boundary", wake, 1'b0);
      chk("R4 no pull before boundary", rstn_pull, 1'b0);
      wait_until(base + v_eff);
      chk("R5 R7 boundary pull", rstn_pull, v_miss);
      chk("R5 R4 boundary wake", wake, ~v_miss);
      if (v_miss) begin
        b2 = tcount;
        wait_until(b2 + R - 1);
        chk("R7 reset width", rstn_pull, 1'b1);
        wait_until(b2 + R);
        chk("R7 reset release", rstn_pull, 1'b0);
        wait_until(b2 + R + v_eff - 1);
        chk("R7 no-wake interval", wake, 1'b0);
        wait_until(b2 + R + v_eff);
        chk("R7 wake after reset spacing", wake, 1'b1);
      end
    end

    // R5: DONE held high across a boundary is not a second acknowledge
    por();
    first_wake(10, 10, base);
    wait_until(base + 1);
    done_in = 1'b1;
    wait_until(base + 10);
    chk("R5 first edge counted", wake, 1'b1);
    wait_until(base + 20);
    chk("R5 held level not an edge", rstn_pull, 1'b1);
    done_in = 1'b0;

    // R8: manual reset overrides an active wake, then a full reset pulse
    por();
    first_wake(10, 10, base);
    mrst_in = 1'b1;
    @(negedge clk);
    chk("R8 wake forced low", wake, 1'b0);
    chk("R8 pull forced", rstn_pull, 1'b1);
    wait_until(tcount + 5);
    chk("R8 pull held", rstn_pull, 1'b1);
    mrst_in = 1'b0;
    r = tcount;
    wait_until(r + R - 1);
    chk("R8 new reset pulse", rstn_pull, 1'b1);
    wait_until(r + R);
    chk("R8 reset release", rstn_pull, 1'b0);
    wait_until(r + R + 9);
    chk("R8 no-wake interval", wake, 1'b0);
    wait_until(r + R + 10);
    chk("R8 interval kept", wake, 1'b1);

    // R9: a later configuration strobe is ignored
    por();
    first_wake(10, 10, base);
    cfg_ticks = CW'(6);
    cfg_valid = 1'b1;
    @(negedge clk);
    cfg_valid = 1'b0;
    pulse_done();
    wait_until(base + 6);
    chk("R9 no early wake", wake, 1'b0);
    wait_until(base + 10);
    chk("R9 period unchanged", wake, 1'b1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule